// File: doc/BRIEF.md
# Read-Modify-Write Bus Sequencer

This block sequences the memory cycles of one read-modify-write instruction for a CPU with a 24-bit address bus. It receives an effective address, a mode flag (compatibility or native), a width flag and a modify-operation code, all captured by a one-cycle start pulse. It then reads the operand, runs one modify cycle, writes the result back and raises a one-cycle done pulse. Computing the address and fetching the opcode are left to other blocks.

The modify cycle behaves differently in the two modes. In compatibility mode it writes the unmodified byte back to the operand address. In native mode it is a dummy read. Neither kind of modify cycle raises the data-valid strobe. A 16-bit result is written back high byte first. The lock output covers every access of the instruction, so an arbiter cannot interleave another master between the read and the write.

Top module: `rmw_seq`

## Requirements
- R1: After reset, and whenever idle, the outputs are busy=0, lock=0, data_valid=0, rwb=1 (1 means read) and done=0.
- R2: A start pulse is accepted only while idle. A start pulse during an operation changes neither its bus cycles nor its result.
- R3: The read begins the cycle after start is accepted. The low byte is read at the address with rwb=1 and data_valid=1. A 16-bit operand then reads its high byte at address+1, which wraps modulo 2^24.
- R4: When emu=1, the operation is 8-bit whatever the value of wide.
- R5: When emu=1, the modify cycle drives rwb=0 and data_valid=0 at the address, with wr_data equal to the byte that was read.
- R6: When emu=0, the modify cycle drives rwb=1 and data_valid=0 at the last address read.
- R7: An 8-bit result is written once at the address. A 16-bit result is written at address+1 with the high byte, then at the address with the low byte. Both writes drive rwb=0 and data_valid=1.
- R8: lock is 1 in every read, modify and write cycle of the operation and 0 at all other times.
- R9: The op codes are 0 increment, 1 decrement, 2 shift left, 3 shift right, 4 rotate left through carry_in, 5 rotate right through carry_in, and 6 and 7 pass the value through unchanged. All results wrap at the operand width, and an 8-bit result has its upper byte zero.
- R10: carry_out is the bit shifted out for codes 2 to 5, and equals carry_in for all other codes.
- R11: done is 1 for exactly the one cycle after the final write. result and carry_out are valid in that cycle and hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| addr_in | input | 24 | Effective operand address |
| emu | input | 1 | 1 = compatibility mode, 0 = native mode |
| wide | input | 1 | 1 = 16-bit operand (native mode only) |
| op | input | 3 | Modify operation code |
| carry_in | input | 1 | Carry used by rotates |
| rd_data | input | 8 | Read data from memory |
| bus_addr | output | 24 | Bus address |
| wr_data | output | 8 | Write data |
| rwb | output | 1 | 1 = read cycle, 0 = write cycle |
| data_valid | output | 1 | Marks a real data access |
| lock | output | 1 | Held across the whole operation |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Modified value |
| carry_out | output | 1 | Carry produced by the operation |

## Verification
The bench uses the default 24-bit address width. It sweeps every combination of mode, width flag, the eight op codes and carry_in, with operands at the width boundaries. Each combination runs at a mid-range address and at the top address, where address+1 wraps to zero. It checks every bus cycle, the done cycle and the following hold cycle. An extra start pulse is injected in the first busy cycle of every operation to show that it is ignored.

// File: rtl/rmw_seq.sv
module rmw_seq #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic                emu,
  input  logic                wide,
  input  logic [2:0]          op,
  input  logic                carry_in,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                rwb,
  output logic                data_valid,
  output logic                lock,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] result,
  output logic                carry_out
);
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {S_IDLE, S_RD_LO, S_RD_HI, S_MOD, S_WR_HI, S_WR_LO} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic              emu_q, wide_q, cin_q;
  logic [2:0]        op_q;
  logic [WORD_W-1:0] opnd_q, res_q;
  logic              cout_q, done_q;
  logic [WORD_W-1:0] mod_res;
  logic              mod_c;

  wire [ADDR_W-1:0] addr_p1 = addr_q + ADDR_W'(1);

  always_comb begin
    logic [WORD_W-1:0] v, msk, top;
    msk = wide_q ? {WORD_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    top = wide_q ? {1'b1, {(WORD_W-1){1'b0}}} : {{BYTE_W{1'b0}}, 1'b1, {(BYTE_W-1){1'b0}}};
    v = opnd_q & msk;
    mod_c = cin_q;
    mod_res = v;
    case (op_q)
      3'd0: mod_res = (v + 1'b1) & msk;
      3'd1: mod_res = (v - 1'b1) & msk;
      3'd2: begin mod_res = (v << 1) & msk; mod_c = |(v & top); end
      3'd3: begin mod_res = v >> 1; mod_c = v[0]; end
      3'd4: begin mod_res = ((v << 1) | WORD_W'(cin_q)) & msk; mod_c = |(v & top); end
      3'd5: begin mod_res = (v >> 1) | (cin_q ? top : '0); mod_c = v[0]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0;
      emu_q <= 1'b0;
      wide_q <= 1'b0;
      cin_q <= 1'b0;
      op_q <= '0;
      opnd_q <= '0;
      res_q <= '0;
      cout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= addr_in;
          emu_q  <= emu;
          wide_q <= wide & ~emu;
          op_q   <= op;
          cin_q  <= carry_in;
          opnd_q <= '0;
          st     <= S_RD_LO;
        end
        S_RD_LO: begin
          opnd_q[BYTE_W-1:0] <= rd_data;
          st <= wide_q ? S_RD_HI : S_MOD;
        end
        S_RD_HI: begin
          opnd_q[WORD_W-1:BYTE_W] <= rd_data;
          st <= S_MOD;
        end
        S_MOD: begin
          res_q  <= mod_res;
          cout_q <= mod_c;
          st <= wide_q ? S_WR_HI : S_WR_LO;
        end
        S_WR_HI: st <= S_WR_LO;
        S_WR_LO: begin
          done_q <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign lock       = busy;
  assign done       = done_q;
  assign result     = res_q;
  assign carry_out  = cout_q;
  assign data_valid = (st == S_RD_LO) || (st == S_RD_HI) || (st == S_WR_HI) || (st == S_WR_LO);
  assign rwb        = !((st == S_WR_HI) || (st == S_WR_LO) || (st == S_MOD && emu_q));
  assign bus_addr   = ((st == S_RD_HI) || (st == S_WR_HI) || (st == S_MOD && wide_q)) ? addr_p1 : addr_q;
  assign wr_data    = (st == S_MOD)   ? opnd_q[BYTE_W-1:0] :
                      (st == S_WR_HI) ? res_q[WORD_W-1:BYTE_W] : res_q[BYTE_W-1:0];
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              lock,
  input logic              data_valid,
  input logic              rwb,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] rd_data,
  input logic              emu_q
);
  p_emu_dummy_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !data_valid && emu_q) |-> (!rwb && wr_data == $past(rd_data)));

  p_native_dummy_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !data_valid && !emu_q) |-> rwb);

  p_high_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rwb && data_valid && $past(!rwb && data_valid)) |-> (bus_addr == $past(bus_addr) - ADDR_W'(1)));

  p_lock_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> done);

  p_modify_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !data_valid) |-> $past(lock && data_valid && rwb));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_until_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

bind rmw_seq rmw_seq_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .lock(lock),
  .data_valid(data_valid), .rwb(rwb), .bus_addr(bus_addr), .wr_data(wr_data),
  .rd_data(rd_data), .emu_q(emu_q)
);

// File: tb/tb_rmw_seq.sv
module tb_rmw_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0, emu = 0, wide = 0, carry_in = 0;
  logic [23:0] addr_in = '0;
  logic [2:0]  op = '0;
  logic [7:0]  rd_data;
  logic [23:0] bus_addr;
  logic [7:0]  wr_data;
  logic        rwb, data_valid, lock, busy, done, carry_out;
  logic [15:0] result;

  logic [23:0] a_cur = '0;
  logic [15:0] v_cur = '0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = (bus_addr == a_cur) ? v_cur[7:0] :
                   (bus_addr == a_cur + 24'd1) ? v_cur[15:8] : 8'hEE;

  rmw_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .emu(emu),
    .wide(wide), .op(op), .carry_in(carry_in), .rd_data(rd_data),
    .bus_addr(bus_addr), .wr_data(wr_data), .rwb(rwb), .data_valid(data_valid),
    .lock(lock), .busy(busy), .done(done), .result(result), .carry_out(carry_out)
  );

  task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_bus(input string req, input logic [23:0] ea, input bit er, input bit ev, input bit cw, input logic [7:0] ed);
    bit ok;
    ok = (bus_addr == ea) && (rwb == er) && (data_valid == ev) && lock && busy && !done && (!cw || wr_data == ed);
    chk(ok, req, "bus cycle {addr,rwb,dv,lock,busy,done,wdata}",
        {bus_addr, 3'b0, rwb, 3'b0, data_valid, 3'b0, lock, 3'b0, busy, 3'b0, done, wr_data},
        {ea, 3'b0, er, 3'b0, ev, 12'h110, ed});
  endtask

  task automatic run(input bit e, input bit w_in, input int o, input bit ci, input logic [23:0] a, input logic [15:0] v);
    bit w;
    int m, vv, r, c;
    logic [23:0] a1;
    w = w_in && !e;
    m = w ? 65536 : 256;
    vv = w ? int'(v) : int'(v[7:0]);
    c = ci;
    case (o)
      0: r = (vv + 1) % m;
      1: r = (vv + m - 1) % m;
      2: begin r = (vv * 2) % m; c = (vv >= m/2) ? 1 : 0; end
      3: begin r = vv / 2; c = vv % 2; end
      4: begin r = (vv * 2) % m + ci; c = (vv >= m/2) ? 1 : 0; end
      5: begin r = vv / 2 + (ci ? m/2 : 0); c = vv % 2; end
      default: r = vv;
    endcase
    a1 = a + 24'd1;
    a_cur = a; v_cur = v;
    addr_in = a; emu = e; wide = w_in; op = 3'(o); carry_in = ci; start = 1;
    @(posedge clk); @(negedge clk);
    start = 1; addr_in = ~a; emu = !e; wide = !w_in; op = 3'(o + 3); carry_in = !ci;
    chk_bus("R3", a, 1, 1, 0, 0);
    @(posedge clk); @(negedge clk);
    start = 0;
    if (w) begin
      chk_bus("R3", a1, 1, 1, 0, 0);
      @(posedge clk); @(negedge clk);
      chk_bus("R6", a1, 1, 0, 0, 0);
      @(posedge clk); @(negedge clk);
      chk_bus("R7", a1, 0, 1, 1, 8'(r >> 8));
      @(posedge clk); @(negedge clk);
      chk_bus("R7", a, 0, 1, 1, 8'(r));
    end else begin
      if (e) chk_bus("R5", a, 0, 0, 1, v[7:0]);
      else   chk_bus("R6", a, 1, 0, 0, 0);
      @(posedge clk); @(negedge clk);
      chk_bus((w_in && e) ? "R4" : "R7", a, 0, 1, 1, 8'(r));
    end
    @(posedge clk); @(negedge clk);
    chk(done && !busy && !lock && !data_valid && rwb, "R11", "done cycle {done,busy,lock,dv,rwb}",
        {done, busy, lock, data_valid, rwb}, 5'b10001);
    chk(result == 16'(r), "R9", "result", result, 16'(r));
    chk(carry_out == c[0], "R10", "carry_out", carry_out, c[0]);
    @(posedge clk); @(negedge clk);
    chk(!done && !busy && !lock && !data_valid && rwb && result == 16'(r) && carry_out == c[0],
        "R1", "idle hold {done,busy,lock,dv,rwb,res,c}",
        {done, busy, lock, data_valid, rwb, result, carry_out}, {5'b00001, 16'(r), c[0]});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] vals [6];
    logic [23:0] addrs [2];
    vals[0] = 16'h0000; vals[1] = 16'h00FF; vals[2] = 16'hFFFF;
    vals[3] = 16'h8000; vals[4] = 16'h7F80; vals[5] = 16'h12A5;
    addrs[0] = 24'h01_2345; addrs[1] = 24'hFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !lock && !data_valid && rwb && !done, "R1", "reset outputs",
        {busy, lock, data_valid, rwb, done}, 5'b00010);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !lock && !done, "R8", "idle lock", {busy, lock, done}, 3'b000);
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 2; w++)
        for (int o = 0; o < 8; o++)
          for (int ci = 0; ci < 2; ci++)
            for (int vi = 0; vi < 6; vi++)
              for (int ai = 0; ai < 2; ai++)
                run(e[0], w[0], o, ci[0], addrs[ai], vals[vi]);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule